// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to 32 interrupt sources and presents them to a processor as one active-low request line. Each source can be set through a 32-bit register bus. Its control word sets how the source triggers: low level, high level, falling edge or rising edge. The same word sets a 3-bit priority. Sources are enabled and disabled one by one through a write-one-to-enable command register and a write-one-to-disable command register. Edge events are held in a pending bit until they are serviced. Software can also force that pending bit on or off.

From all enabled, active sources an arbiter picks the one with the highest priority. The processor reads a vector register, which returns the chosen source number times four. That read also acknowledges the interrupt: the request line is released and the number of the acknowledged source is held. Service ends when the processor writes anything to the end-of-service register. Only then can a new request be raised. Status registers show the raw inputs, the per-source active state, the active-and-enabled state and the request line itself.

Top module: `vec_prio_intc`

## Requirements
- R1: Source n has a control word at byte offset 4*n. Bits [7:6] give the trigger (0 low level, 1 high level, 2 falling edge, 3 rising edge) and bits [2:0] give the priority. A read returns only those bits and zeros elsewhere. After reset every control word reads 0x40 (high level, priority 0).
- R2: After reset every source is disabled, the enable register at 0x114 reads 0 and irq_n_o is high.
- R3: For each bit written as 1, a write to 0x120 enables that source and a write to 0x124 disables it. Bits written as 0 leave their source unchanged. Register 0x114 reads back the enables, with 1 meaning enabled.
- R4: A level-triggered source is active while its input is at the selected level, and stops being active as soon as the input leaves that level. Nothing is latched.
- R5: An edge-triggered source latches a pending bit on the selected edge. The bit stays set after the input returns.
- R6: Among enabled, active sources the highest priority value wins (7 highest). On a tie the lowest source number wins.
- R7: A read of 0x10C returns the winning source number times four and acknowledges it. It clears that source's edge pending bit, releases irq_n_o and makes 0x110 hold the acknowledged number. With no request, the read returns 0 and acknowledges nothing.
- R8: From acknowledge until a write of any value to 0x130, irq_n_o stays high even if new sources become active. After that write, a pending request asserts irq_n_o again.
- R9: A 1 written to a bit of 0x128 sets the pending bit of an edge-triggered source, and a 1 written to a bit of 0x12C clears it. Neither has any effect on a level-triggered source.
- R10: 0x100 reads the raw inputs, 0x104 the per-source active state, 0x108 the active state ANDed with the enables, and bit 0 of 0x118 is 1 while the request is asserted.
- R11: irq_n_o is low exactly when at least one enabled source is active and no service is in progress. A disabled pending source does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe, one cycle per access |
| bus_rd_i | input | 1 | Register read strobe, one cycle per access |
| bus_addr_i | input | 10 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of bus_rd_i |
| src_i | input | 32 | Raw interrupt source inputs |
| irq_n_o | output | 1 | Interrupt request to the processor, active low |

## Verification
Arbitration is driven by a table of source pairs. The pairs cover one priority above another, equal priorities with neighbouring numbers, the extreme priorities, and the highest numbered sources. Each case must show whether the priority comparison or the tie rule on the lower number decided the winner. Each trigger type is driven separately: a high level that drops, a low level, a rising pulse and a falling pulse. These show that levels follow their input while edges stay latched. A second edge that arrives while a source is being serviced checks that the request stays off until end-of-service and then comes back. Software set and clear are applied to both an edge source and a level source to show they act only on the edge source.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_RISE = 2'd3
  } trig_e;

  localparam logic [9:0] OFS_RAW  = 10'h100;
  localparam logic [9:0] OFS_ACT  = 10'h104;
  localparam logic [9:0] OFS_INT  = 10'h108;
  localparam logic [9:0] OFS_VEC  = 10'h10C;
  localparam logic [9:0] OFS_NUM  = 10'h110;
  localparam logic [9:0] OFS_ENA  = 10'h114;
  localparam logic [9:0] OFS_OUT  = 10'h118;
  localparam logic [9:0] OFS_MEN  = 10'h120;
  localparam logic [9:0] OFS_MDIS = 10'h124;
  localparam logic [9:0] OFS_SET  = 10'h128;
  localparam logic [9:0] OFS_CLR  = 10'h12C;
  localparam logic [9:0] OFS_EOS  = 10'h130;

  // vector read value: source number scaled to a word offset
  function automatic logic [31:0] vec_code(input logic [31:0] id);
    return id << 2;
  endfunction

  function automatic logic is_edge(input trig_e t);
    return t[1];
  endfunction

  function automatic logic level_hit(input trig_e t, input logic s);
    return (t == TRIG_HIGH) ? s : ~s;
  endfunction

  function automatic logic edge_seen(input trig_e t, input logic s, input logic prev);
    case (t)
      TRIG_RISE: return s & ~prev;
      TRIG_FALL: return ~s & prev;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/vpic_src_detect.sv
module vpic_src_detect
  import vpic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  trig_e              trig_i [NUM_SRC],
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic [NUM_SRC-1:0] ack_i,
  output logic [NUM_SRC-1:0] active_o,
  output logic [NUM_SRC-1:0] edge_hit_o
);

  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src_i;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic edge_mode;
    assign edge_mode     = is_edge(trig_i[g]);
    assign edge_hit_o[g] = edge_seen(trig_i[g], src_i[g], prev_q[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      pend_q[g] <= 1'b0;
      else if (!edge_mode)             pend_q[g] <= 1'b0;
      else if (edge_hit_o[g] || set_i[g]) pend_q[g] <= 1'b1;
      else if (clr_i[g] || ack_i[g])   pend_q[g] <= 1'b0;
    end

    assign active_o[g] = edge_mode ? pend_q[g] : level_hit(trig_i[g], src_i[g]);

    AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit_o[g] |=> pend_q[g]); // R5

    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && (ack_i[g] || clr_i[g]) && !set_i[g] && !edge_hit_o[g]) |=> !pend_q[g]); // R9
  end

endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 3,
  localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [PRIO_W-1:0] prio_i [NUM_SRC],
  output logic              win_vld_o,
  output logic [ID_W-1:0]   win_id_o
);

  logic [PRIO_W-1:0] best;

  // scan from the top number down; ">=" lets a lower number take a tie
  always_comb begin
    win_vld_o = 1'b0;
    win_id_o  = '0;
    best      = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i] && (!win_vld_o || prio_i[i] >= best)) begin
        win_vld_o = 1'b1;
        best      = prio_i[i];
        win_id_o  = ID_W'(i);
      end
    end
  end

  AST_WIN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld_o |-> req_i[win_id_o]); // R6

  AST_WIN_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |-> win_vld_o); // R11

endmodule

// File: rtl/vec_prio_intc.sv
module vec_prio_intc
  import vpic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,  // at most 32: one bit per source in a bus word
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned ADDR_W  = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_n_o
);

  localparam int unsigned ID_W    = $clog2(NUM_SRC);
  localparam int unsigned CFG_TOP = 4 * NUM_SRC;

  trig_e              trig_q [NUM_SRC];
  logic [PRIO_W-1:0]  prio_q [NUM_SRC];
  logic [NUM_SRC-1:0] en_q;
  logic               busy_q;
  logic [ID_W-1:0]    held_q;

  logic [NUM_SRC-1:0] active, edge_hit, int_stat, ack_vec;
  logic               win_vld;
  logic [ID_W-1:0]    win_id;

  // named bus events
  logic cfg_hit, wr_men, wr_mdis, wr_set, wr_clr, eoi, ack;
  logic [ID_W-1:0] cfg_idx;
  logic [NUM_SRC-1:0] wbits;

  assign cfg_hit = (32'(bus_addr_i) < CFG_TOP) && (bus_addr_i[1:0] == 2'b00);
  assign cfg_idx = bus_addr_i[ID_W+1:2];
  assign wbits   = bus_wdata_i[NUM_SRC-1:0];
  assign wr_men  = bus_wr_i && (bus_addr_i == OFS_MEN);
  assign wr_mdis = bus_wr_i && (bus_addr_i == OFS_MDIS);
  assign wr_set  = bus_wr_i && (bus_addr_i == OFS_SET);
  assign wr_clr  = bus_wr_i && (bus_addr_i == OFS_CLR);
  assign eoi     = bus_wr_i && (bus_addr_i == OFS_EOS);
  assign ack     = bus_rd_i && (bus_addr_i == OFS_VEC) && !busy_q && win_vld;
  assign ack_vec = ack ? ({{(NUM_SRC-1){1'b0}}, 1'b1} << win_id) : '0;

  vpic_src_detect #(.NUM_SRC(NUM_SRC)) u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      (src_i),
    .trig_i     (trig_q),
    .set_i      (wr_set ? wbits : '0),
    .clr_i      (wr_clr ? wbits : '0),
    .ack_i      (ack_vec),
    .active_o   (active),
    .edge_hit_o (edge_hit)
  );

  assign int_stat = active & en_q;

  vpic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (int_stat),
    .prio_i    (prio_q),
    .win_vld_o (win_vld),
    .win_id_o  (win_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        trig_q[i] <= TRIG_HIGH;
        prio_q[i] <= '0;
      end
    end else if (bus_wr_i && cfg_hit) begin
      trig_q[cfg_idx] <= trig_e'(bus_wdata_i[7:6]);
      prio_q[cfg_idx] <= bus_wdata_i[PRIO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (wr_men)  en_q <= en_q | wbits;
    else if (wr_mdis) en_q <= en_q & ~wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      held_q <= '0;
    end else if (eoi) begin
      busy_q <= 1'b0;
    end else if (ack) begin
      busy_q <= 1'b1;
      held_q <= win_id;
    end
  end

  assign irq_n_o = ~(win_vld && !busy_q);

  always_comb begin
    bus_rdata_o = '0;
    if (cfg_hit) begin
      bus_rdata_o[7:6]        = trig_q[cfg_idx];
      bus_rdata_o[PRIO_W-1:0] = prio_q[cfg_idx];
    end else begin
      case (bus_addr_i)
        OFS_RAW: bus_rdata_o[NUM_SRC-1:0] = src_i;
        OFS_ACT: bus_rdata_o[NUM_SRC-1:0] = active;
        OFS_INT: bus_rdata_o[NUM_SRC-1:0] = int_stat;
        OFS_ENA: bus_rdata_o[NUM_SRC-1:0] = en_q;
        OFS_NUM: bus_rdata_o[ID_W-1:0]    = held_q;
        OFS_OUT: bus_rdata_o[0]           = ~irq_n_o;
        OFS_VEC: bus_rdata_o = busy_q  ? vec_code(32'(held_q)) :
                               win_vld ? vec_code(32'(win_id)) : '0;
        default: bus_rdata_o = '0;
      endcase
    end
  end

  AST_SERVICE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> irq_n_o); // R8

  AST_ACK_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (busy_q && irq_n_o)); // R7

  AST_EOI_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |=> !busy_q); // R8

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !bus_rd_i && !bus_wr_i) |=> $stable(held_q)); // R7

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_men |=> ((en_q & $past(wbits)) == $past(wbits))); // R3

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mdis |=> ((en_q & $past(wbits)) == '0)); // R3

  AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n_o |-> ((active & en_q) != '0)); // R11

endmodule

// File: tb/tb_vec_prio_intc.sv
`timescale 1ns/1ps
module tb_vec_prio_intc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] src = '0;
  logic        irq_n;
  int          n_chk = 0, n_err = 0;

  always #10 clk = ~clk;  // 50 MHz

  vec_prio_intc dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .src_i(src), .irq_n_o(irq_n)
  );

  // {src_a, prio_a, src_b, prio_b, expected winner}
  localparam logic [20:0] PAIRS [6] = '{
    {5'd1,  3'd3, 5'd2,  3'd5, 5'd2 },
    {5'd6,  3'd4, 5'd7,  3'd4, 5'd6 },
    {5'd20, 3'd7, 5'd0,  3'd0, 5'd20},
    {5'd31, 3'd1, 5'd30, 3'd1, 5'd30},
    {5'd15, 3'd0, 5'd16, 3'd0, 5'd15},
    {5'd25, 3'd6, 5'd3,  3'd2, 5'd25}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // reset state
    check("R2 irq after reset", 32'(irq_n), 32'd1);
    rd(10'h114, v); check("R2 enables after reset", v, 32'h0);
    rd(10'h000, v); check("R1 control reset value", v, 32'h40);

    // control word layout
    wr(10'h014, 32'hFFFF_FFFF);
    rd(10'h014, v); check("R1 control readback", v, 32'hC7);
    wr(10'h014, 32'h40);

    // enable / disable commands
    wr(10'h120, 32'h0000_00F0); rd(10'h114, v); check("R3 enable set", v, 32'hF0);
    wr(10'h120, 32'h0000_0001); rd(10'h114, v); check("R3 zero bits keep", v, 32'hF1);
    wr(10'h124, 32'h0000_0010); rd(10'h114, v); check("R3 disable one", v, 32'hE1);
    wr(10'h124, 32'hFFFF_FFFF); rd(10'h114, v); check("R3 disable all", v, 32'h0);

    // arbitration table, high-level sources
    for (int k = 0; k < 6; k++) begin
      logic [4:0] a, b, e;
      logic [2:0] pa, pb;
      {a, pa, b, pb, e} = PAIRS[k];
      wr(10'(4 * a), {24'd0, 2'd1, 3'd0, pa});
      wr(10'(4 * b), {24'd0, 2'd1, 3'd0, pb});
      wr(10'h120, (32'd1 << a) | (32'd1 << b));
      src = (32'd1 << a) | (32'd1 << b);
      settle();
      check("R11 irq with pair", 32'(irq_n), 32'd0);
      rd(10'h10C, v); check("R6 winner vector", v, 32'(e) << 2);
      rd(10'h110, v); check("R7 held number", v, 32'(e));
      src = '0;
      wr(10'h130, 32'h0);
      wr(10'h124, (32'd1 << a) | (32'd1 << b));
    end

    // high level follows input
    wr(10'h00C, 32'h43); wr(10'h120, 32'h8);
    @(negedge clk); src[3] = 1'b1; #1;
    check("R4 high level asserts", 32'(irq_n), 32'd0);
    rd(10'h118, v); check("R10 output status", v, 32'h1);
    rd(10'h100, v); check("R10 raw status", v, 32'h8);
    @(negedge clk); src[3] = 1'b0; #1;
    check("R4 high level drops", 32'(irq_n), 32'd1);
    rd(10'h118, v); check("R10 output status idle", v, 32'h0);
    // software set ignored on level source
    wr(10'h128, 32'h8); rd(10'h104, v); check("R9 set ignored on level", v, 32'h0);
    wr(10'h124, 32'h8);

    // low level
    @(negedge clk); src[4] = 1'b1;
    wr(10'h010, 32'h02); wr(10'h120, 32'h10);
    settle(); check("R4 low level idle high", 32'(irq_n), 32'd1);
    src[4] = 1'b0; #1;
    check("R4 low level asserts", 32'(irq_n), 32'd0);
    rd(10'h10C, v); check("R7 low level vector", v, 32'h10);
    src[4] = 1'b1;
    wr(10'h130, 32'h0);
    settle(); check("R8 idle after eoi", 32'(irq_n), 32'd1);
    wr(10'h124, 32'h10);

    // rising edge, with a second edge arriving during service
    wr(10'h020, 32'hC4); wr(10'h024, 32'hC1); wr(10'h120, 32'h300);
    @(negedge clk); src[8] = 1'b1;
    @(negedge clk); src[8] = 1'b0;
    settle();
    check("R5 rising latched", 32'(irq_n), 32'd0);
    rd(10'h104, v); check("R10 active status edge", v, 32'h100);
    rd(10'h10C, v); check("R7 edge vector", v, 32'h20);
    #1 check("R7 irq released", 32'(irq_n), 32'd1);
    rd(10'h104, v); check("R7 pending cleared by ack", v, 32'h0);
    @(negedge clk); src[9] = 1'b1;
    @(negedge clk); src[9] = 1'b0;
    settle();
    check("R8 quiet during service", 32'(irq_n), 32'd1);
    rd(10'h10C, v); check("R7 vector during service", v, 32'h20);
    rd(10'h110, v); check("R8 number held", v, 32'd8);
    wr(10'h130, 32'hDEAD_BEEF);
    #1 check("R8 reasserts after eoi", 32'(irq_n), 32'd0);
    rd(10'h10C, v); check("R7 second vector", v, 32'h24);
    wr(10'h130, 32'h0);
    #1 check("R8 idle after second eoi", 32'(irq_n), 32'd1);
    wr(10'h124, 32'h300);

    // falling edge
    wr(10'h028, 32'h81); wr(10'h120, 32'h400);
    @(negedge clk); src[10] = 1'b1;
    settle(); check("R5 no falling yet", 32'(irq_n), 32'd1);
    src[10] = 1'b0;
    settle(); settle();
    rd(10'h104, v); check("R5 falling latched", v, 32'h400);
    rd(10'h10C, v); check("R7 falling vector", v, 32'h28);
    wr(10'h130, 32'h0); wr(10'h124, 32'h400);

    // software set/clear and masking of a pending edge
    wr(10'h030, 32'hC2);
    wr(10'h128, 32'h1000);
    rd(10'h104, v); check("R9 software set", v, 32'h1000);
    rd(10'h108, v); check("R10 masked int status", v, 32'h0);
    #1 check("R11 masked pending quiet", 32'(irq_n), 32'd1);
    wr(10'h120, 32'h1000);
    #1 check("R11 enabled pending asserts", 32'(irq_n), 32'd0);
    rd(10'h108, v); check("R10 int status", v, 32'h1000);
    wr(10'h12C, 32'h1000);
    rd(10'h104, v); check("R9 software clear", v, 32'h0);
    #1 check("R9 irq after clear", 32'(irq_n), 32'd1);

    // vector read with nothing pending
    rd(10'h10C, v); check("R7 empty vector", v, 32'h0);
    wr(10'h128, 32'h1000);
    #1 check("R7 empty read did not ack", 32'(irq_n), 32'd0);
    wr(10'h12C, 32'h1000);
    wr(10'h124, 32'hFFFF_FFFF);
    rd(10'h114, v); check("R3 final disable all", v, 32'h0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule